// File: doc/BRIEF.md
# Supply and Watchdog Reset Generator

This block drives a single system reset line from two sources. The first is a synchronous supply-good flag. The second is a watchdog input that shares the chip-select wire of a serial bus. The line is held while the supply flag is low. Once the supply comes back, the line stays held for a fixed release delay, counted in clock cycles. The watchdog also forces the line when the shared select input goes too long without a high-to-low transition.

The watchdog period comes from a two-bit selector, which in the system is wired from an external status register. Three codes pick one of three preset timeouts, and the fourth code turns the watchdog off. Every reset, whatever its cause, ends with the same release delay. A parameter chooses an active-low or an active-high output.

The voltage comparator, the trip level and the pad driver are outside the block. The supply condition arrives already synchronous to the clock.

Top module: `sup_wd_reset`

## Requirements
- R1: While `rst` is high at a clock edge, the reset output is asserted after that edge, and the release count and the watchdog count both restart from zero.
- R2: After `rst` falls with `supply_ok` high, the output stays asserted for exactly `RELEASE_CYCLES` clock edges and deasserts after the following edge.
- R3: A low `supply_ok` sampled at an edge leaves the output asserted after that edge, whatever state the block was in.
- R4: If `supply_ok` drops while a release delay is running, the delay restarts from zero and needs a full `RELEASE_CYCLES` of good supply again.
- R5: `cs_wdi` passes through a two-flop synchroniser and an edge register. A high-to-low transition sampled at edge k clears the watchdog count at edge k+2.
- R6: `wd_sel` encoding is 2'b00 for `WD_SHORT`, 2'b01 for `WD_MED` and 2'b10 for `WD_LONG` cycles. When the count reaches that many consecutive run cycles with no recognised falling edge, the output asserts after the next edge.
- R7: With `wd_sel` = 2'b11 the watchdog is off. A constant `cs_wdi` then never asserts the output.
- R8: A watchdog reset lasts exactly `RELEASE_CYCLES` edges. The watchdog then counts from zero again.
- R9: While reset is held for a supply fault, the watchdog count stays cleared. After release, a full timeout is needed before a watchdog reset.
- R10: With `ACTIVE_HIGH` = 0 the output is low when asserted. With `ACTIVE_HIGH` = 1 it is high when asserted.
- R11: A low-to-high transition on `cs_wdi` does not restart the watchdog.
- R12: If `wd_sel` changes to a shorter timeout while the count already exceeds that limit, the watchdog expires on the next run cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Synchronous supply-good flag |
| cs_wdi | input | 1 | Shared chip-select / watchdog input, asynchronous |
| wd_sel | input | 2 | Watchdog period select from the status register |
| rst_out | output | 1 | System reset, polarity set by `ACTIVE_HIGH` |

## Verification
The bench builds two copies with short counts: a release delay of 20 cycles and timeouts of 8, 16 and 32. One copy is active-low and the other active-high, and both share the same stimulus. The small counts let a short run reach every timeout, complete watchdog holds, supply drops in the middle of a hold, and a switch to a shorter period after the count has already passed its limit. The paired copies check both output polarities on every cycle.

// File: rtl/sup_wd_pkg.sv
package sup_wd_pkg;

    typedef enum logic [1:0] {
        ST_PWR_HOLD = 2'd0,
        ST_RUN      = 2'd1,
        ST_WD_HOLD  = 2'd2
    } sv_state_e;

    typedef enum logic [1:0] {
        WDSEL_SHORT = 2'b00,
        WDSEL_MED   = 2'b01,
        WDSEL_LONG  = 2'b10,
        WDSEL_OFF   = 2'b11
    } wd_sel_e;

    typedef struct packed {
        logic asserted;
        logic wd_cause;
    } rst_status_t;

    function automatic logic wd_enabled(input logic [1:0] sel);
        return sel != WDSEL_OFF;
    endfunction

endpackage

// File: rtl/sv_wdi_sync.sv
module sv_wdi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain[STAGES-1];
    end

    assign fall = last_q & ~chain[STAGES-1];

endmodule

// File: rtl/sv_wdog_counter.sv
module sv_wdog_counter
    import sup_wd_pkg::*;
#(
    parameter int unsigned WD_SHORT = 150000,
    parameter int unsigned WD_MED   = 600000,
    parameter int unsigned WD_LONG  = 1400000,
    localparam int unsigned WDW     = $clog2(WD_LONG + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           kick,
    input  logic [1:0]     sel,
    output logic           expire,
    output logic [WDW-1:0] count
);
    localparam logic [WDW-1:0] LIM_S = WDW'(WD_SHORT - 1);
    localparam logic [WDW-1:0] LIM_M = WDW'(WD_MED - 1);
    localparam logic [WDW-1:0] LIM_L = WDW'(WD_LONG - 1);

    logic [WDW-1:0] limit_m1;
    logic           enabled;

    always_comb begin
        unique case (sel)
            WDSEL_SHORT: limit_m1 = LIM_S;
            WDSEL_MED:   limit_m1 = LIM_M;
            default:     limit_m1 = LIM_L;
        endcase
    end

    assign enabled = wd_enabled(sel);
    assign expire  = run && enabled && !kick && (count >= limit_m1);

    always_ff @(posedge clk) begin
        if (rst || !run || kick || !enabled) count <= '0;
        else if (count != {WDW{1'b1}})       count <= count + 1'b1;
    end

endmodule

// File: rtl/sv_release_timer.sv
module sv_release_timer
    import sup_wd_pkg::*;
#(
    parameter int unsigned RELEASE_CYCLES = 200000,
    localparam int unsigned RELW          = $clog2(RELEASE_CYCLES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        supply_ok,
    input  logic        wd_expire,
    output sv_state_e   state,
    output rst_status_t status
);
    localparam logic [RELW-1:0] REL_LAST = RELW'(RELEASE_CYCLES - 1);

    logic [RELW-1:0] rel_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_PWR_HOLD;
            rel_cnt <= '0;
        end else if (!supply_ok) begin
            state   <= ST_PWR_HOLD;
            rel_cnt <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    rel_cnt <= '0;
                    if (wd_expire) state <= ST_WD_HOLD;
                end
                ST_PWR_HOLD, ST_WD_HOLD: begin
                    if (rel_cnt == REL_LAST) begin
                        state   <= ST_RUN;
                        rel_cnt <= '0;
                    end else begin
                        rel_cnt <= rel_cnt + 1'b1;
                    end
                end
                default: begin
                    state   <= ST_PWR_HOLD;
                    rel_cnt <= '0;
                end
            endcase
        end
    end

    assign status.asserted = (state != ST_RUN);
    assign status.wd_cause = (state == ST_WD_HOLD);

    // R3: a supply fault always leaves reset held
    a_r3_supply_fault_holds: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> status.asserted);

    // R6: an expiry with good supply enters the watchdog hold
    a_r6_expire_enters_hold: assert property (@(posedge clk) disable iff (rst)
        (wd_expire && supply_ok) |=> (state == ST_WD_HOLD));

    // R2: release only after the full count of good supply
    a_r2_release_after_count: assert property (@(posedge clk) disable iff (rst)
        $fell(status.asserted) |-> ($past(rel_cnt) == REL_LAST && $past(supply_ok)));

endmodule

// File: rtl/sup_wd_reset.sv
module sup_wd_reset
    import sup_wd_pkg::*;
#(
    parameter int unsigned RELEASE_CYCLES = 200000,
    parameter int unsigned WD_SHORT       = 150000,
    parameter int unsigned WD_MED         = 600000,
    parameter int unsigned WD_LONG        = 1400000,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter bit          ACTIVE_HIGH    = 1'b0,
    localparam int unsigned WDW           = $clog2(WD_LONG + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       cs_wdi,
    input  logic [1:0] wd_sel,
    output logic       rst_out
);
    logic           wdi_fall;
    logic           wd_expire;
    logic [WDW-1:0] wd_cnt;
    sv_state_e      state;
    rst_status_t    status;

    sv_wdi_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (cs_wdi),
        .fall (wdi_fall)
    );

    sv_wdog_counter #(
        .WD_SHORT (WD_SHORT),
        .WD_MED   (WD_MED),
        .WD_LONG  (WD_LONG)
    ) wdog_i (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_RUN),
        .kick   (wdi_fall),
        .sel    (wd_sel),
        .expire (wd_expire),
        .count  (wd_cnt)
    );

    sv_release_timer #(.RELEASE_CYCLES(RELEASE_CYCLES)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .wd_expire (wd_expire),
        .state     (state),
        .status    (status)
    );

    generate
        if (ACTIVE_HIGH) begin : g_pol_high
            assign rst_out = status.asserted;
        end else begin : g_pol_low
            assign rst_out = ~status.asserted;
        end
    endgenerate

    // R9: the watchdog count stays clear through a supply hold
    a_r9_wd_clear_in_pwr_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PWR_HOLD && $past(state) == ST_PWR_HOLD) |-> (wd_cnt == '0));

    // R8: leaving a watchdog hold restarts the count from zero
    a_r8_wd_restart_after_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(status.wd_cause) && state == ST_RUN) |-> (wd_cnt == '0));

    // R7: with the watchdog off, run continues while supply is good
    a_r7_off_stays_run: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && wd_sel == WDSEL_OFF && supply_ok) |=> (state == ST_RUN));

endmodule

// File: tb/sup_wd_reset_tb_top.sv
module sup_wd_reset_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REL  = 20;
    localparam int WS   = 8;
    localparam int WM   = 16;
    localparam int WL   = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok = 1'b1;
    logic       cs_wdi = 1'b1;
    logic [1:0] wd_sel = 2'b00;
    logic       out_lo, out_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    sup_wd_reset #(.RELEASE_CYCLES(REL), .WD_SHORT(WS), .WD_MED(WM), .WD_LONG(WL),
                   .ACTIVE_HIGH(1'b0)) dut_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .cs_wdi(cs_wdi),
        .wd_sel(wd_sel), .rst_out(out_lo));

    sup_wd_reset #(.RELEASE_CYCLES(REL), .WD_SHORT(WS), .WD_MED(WM), .WD_LONG(WL),
                   .ACTIVE_HIGH(1'b1)) dut_hi_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .cs_wdi(cs_wdi),
        .wd_sel(wd_sel), .rst_out(out_hi));

    typedef struct {
        logic  asserted;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R1";
    bit    done     = 0;

    // reference state, written from the requirement text
    int m_st  = 0;   // 0 supply hold, 1 run, 2 watchdog hold
    int m_rel = 0;
    int m_wd  = 0;
    logic [2:0] m_hist = 3'b111; // [0] newest sample of cs_wdi

    task automatic step(input logic sup, input logic cs, input logic [1:0] sel,
                        input logic r);
        int nst, nrel, nwd, lim;
        logic kick, en, expire;
        exp_t e;
        @(negedge clk);
        rst = r; supply_ok = sup; cs_wdi = cs; wd_sel = sel;
        kick = m_hist[2] & ~m_hist[1];
        nst = m_st; nrel = m_rel; nwd = m_wd;
        if (r) begin
            nst = 0; nrel = 0; nwd = 0; m_hist = 3'b111;
        end else begin
            en  = (sel != 2'b11);
            lim = (sel == 2'b00) ? WS : (sel == 2'b01) ? WM : WL;
            expire = (m_st == 1) && en && !kick && (m_wd >= lim - 1);
            nwd = (m_st != 1 || kick || !en) ? 0 : m_wd + 1;
            if (!sup) begin
                nst = 0; nrel = 0;
            end else if (m_st == 1) begin
                nrel = 0;
                if (expire) nst = 2;
            end else if (m_rel == REL - 1) begin
                nst = 1; nrel = 0;
            end else begin
                nrel = m_rel + 1;
            end
            m_hist = {m_hist[1:0], cs};
        end
        m_st = nst; m_rel = nrel; m_wd = nwd;
        e.asserted = (nst != 1);
        e.tag = cur_tag;
        sb_q.push_back(e);
    endtask

    task automatic run_n(input int n, input logic sup, input logic cs,
                         input logic [1:0] sel);
        for (int i = 0; i < n; i++) step(sup, cs, sel, 1'b0);
    endtask

    task automatic kick_n(input int n, input int period, input logic [1:0] sel);
        for (int i = 0; i < n; i++) step(1'b1, (i % period) != 0, sel, 1'b0);
    endtask

    // monitor: compares each cycle away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (out_lo !== ~e.asserted) begin
                    n_fail++;
                    $display("FAIL %s (R10 low polarity): out=%b expected=%b at %0t",
                             e.tag, out_lo, ~e.asserted, $time);
                end
                n_checks++;
                if (out_hi !== e.asserted) begin
                    n_fail++;
                    $display("FAIL %s (R10 high polarity): out=%b expected=%b at %0t",
                             e.tag, out_hi, e.asserted, $time);
                end
            end
        end
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 2'b00, 1'b1);
        // R2: power-up release delay
        cur_tag = "R2";
        kick_n(REL + 4, 3, 2'b00);
        // R5: regular kicks keep the short watchdog quiet
        cur_tag = "R5";
        kick_n(60, 6, 2'b00);
        // R6: short timeout with input held high, then R8 hold length
        cur_tag = "R6";
        run_n(WS + 4, 1'b1, 1'b1, 2'b00);
        cur_tag = "R8";
        run_n(REL + 3, 1'b1, 1'b1, 2'b11);
        kick_n(20, 5, 2'b00);
        // R6: medium timeout with input held low
        cur_tag = "R6";
        run_n(WM + 3, 1'b1, 1'b0, 2'b01);
        run_n(REL + 2, 1'b1, 1'b0, 2'b01);
        // R6: long timeout
        cur_tag = "R6";
        kick_n(8, 4, 2'b10);
        run_n(WL + 3, 1'b1, 1'b1, 2'b10);
        run_n(REL + 2, 1'b1, 1'b0, 2'b11);
        // R7: watchdog off with constant input
        cur_tag = "R7";
        run_n(3 * WL, 1'b1, 1'b0, 2'b11);
        run_n(3 * WL, 1'b1, 1'b1, 2'b11);
        // R11: only rising edges, no restart
        cur_tag = "R11";
        kick_n(6, 3, 2'b00);
        run_n(3, 1'b1, 1'b0, 2'b00);
        run_n(WS + 2, 1'b1, 1'b1, 2'b00);
        run_n(REL + 2, 1'b1, 1'b1, 2'b11);
        // R3: supply drop while running
        cur_tag = "R3";
        run_n(4, 1'b0, 1'b1, 2'b11);
        // R4: supply drop in the middle of the release delay
        cur_tag = "R4";
        run_n(REL / 2, 1'b1, 1'b1, 2'b11);
        run_n(2, 1'b0, 1'b1, 2'b11);
        run_n(REL + 2, 1'b1, 1'b1, 2'b11);
        // R9: supply hold keeps the watchdog clear, full timeout after release
        cur_tag = "R9";
        run_n(WS - 3, 1'b1, 1'b1, 2'b00);
        run_n(5, 1'b0, 1'b1, 2'b00);
        run_n(REL + WS + 3, 1'b1, 1'b1, 2'b00);
        run_n(REL + 2, 1'b1, 1'b0, 2'b11);
        // R12: switch to a shorter period past its limit
        cur_tag = "R12";
        run_n(WM + 2, 1'b1, 1'b0, 2'b10);
        run_n(3, 1'b1, 1'b0, 2'b00);
        run_n(REL + 2, 1'b1, 1'b0, 2'b11);
        // R1: reset in the middle of run
        cur_tag = "R1";
        kick_n(10, 4, 2'b00);
        step(1'b1, 1'b1, 2'b00, 1'b1);
        step(1'b1, 1'b1, 2'b00, 1'b1);
        cur_tag = "R2";
        kick_n(REL + 3, 4, 2'b00);
        @(negedge clk);
        @(negedge clk);
        done = 1;
    end

    initial begin : watchdog_blk
        int cyc;
        cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule